// File: doc/BRIEF.md
# High-Side Bias Startup and Undervoltage Sequencer

This block decides when a high-side switch channel may be driven. It watches a digital sample of the floating gate-bias rail, delivered with a valid strobe. It compares that sample against two programmable levels: an upper level that arms the channel and a lower level that removes drive. Until the rail is healthy, it asks the low-side switch for short periodic pulses. These pulses pull the switch node down so that the bootstrap capacitor can recharge. High-side permission is granted only after the rail has stayed above the upper level for a programmable number of consecutive samples.

Once armed, the channel moves between a ready state and a switching state under the start request. If the rail sags below the lower level, the block drops into a latched fault state with all permissions removed. A missing startup within a programmable cycle budget also causes a fault. Leaving the fault needs an explicit clear while the rail is healthy. Every entry into the fault state is tallied in a saturating counter, so threshold chatter can be observed.

Top module: `hs_bias_sequencer`

## Requirements
- R1: State encoding is PRECHARGE=0, READY=1, SWITCHING=2, FAULT=3 on `state_o`. After reset the state is PRECHARGE, and `pc_ls_req`, `bias_ready`, `pwm_en` and `chatter_cnt` are all 0.
- R2: PRECHARGE moves to READY on the clock edge that sees the N-th consecutive valid sample strictly greater than `th_on` while `start_req` is 1. N is `settle_len`, and a value of 0 acts as 1. A sample equal to `th_on` does not qualify.
- R3: During the settle count, a valid sample less than or equal to `th_on` restarts the count from zero. Cycles without a valid strobe neither add to the count nor clear it. A low `start_req` clears the count.
- R4: In READY or SWITCHING, a valid sample strictly below `th_off` moves the state to FAULT on that edge. A sample equal to `th_off` does not. In FAULT, `bias_ready` and `pwm_en` are 0.
- R5: In PRECHARGE with `start_req` high, `pc_ls_req` is high for the first `pc_width` cycles of every `pc_period` cycles, where a period of 0 acts as 1. The pattern restarts at phase 0 whenever precharge becomes active. `pc_ls_req` is 0 in every other case.
- R6: `pwm_en` is 1 only in SWITCHING. `bias_ready` is 1 in READY and SWITCHING. READY moves to SWITCHING when `start_req` is 1, and SWITCHING returns to READY when `start_req` is 0.
- R7: FAULT moves to PRECHARGE only on an edge where `fault_clr` is 1 and a valid sample strictly above `th_on` is present. Either condition alone leaves the state in FAULT.
- R8: `chatter_cnt` adds one on every entry into FAULT and holds at all ones.
- R9: In active PRECHARGE with nonzero `timeout_len`, the state moves to FAULT on the `timeout_len`-th active cycle edge if READY has not been reached. If READY qualifies on the same edge, READY wins. A `timeout_len` of 0 disables the timeout, and a low `start_req` clears the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_valid | input | 1 | Strobe marking a new bias sample |
| bias_sample | input | BIAS_W | Digitised floating-bias value |
| th_on | input | BIAS_W | Arming (upper) threshold |
| th_off | input | BIAS_W | Drop-out (lower) threshold |
| settle_len | input | SETTLE_W | Consecutive qualifying samples needed |
| pc_period | input | PC_W | Precharge pulse period in cycles |
| pc_width | input | PC_W | Precharge pulse high time in cycles |
| timeout_len | input | TMO_W | Startup cycle budget, 0 disables |
| start_req | input | 1 | Request to bring up and run the channel |
| fault_clr | input | 1 | Request to leave FAULT |
| state_o | output | 2 | Current state code |
| pc_ls_req | output | 1 | Low-side precharge pulse request |
| bias_ready | output | 1 | Bias qualified, high side may be driven |
| pwm_en | output | 1 | PWM switching permitted |
| chatter_cnt | output | CHAT_W | Saturating count of FAULT entries |

## Verification
Several rules are checked on every cycle:
- FAULT removes both permissions.
- `pwm_en` never appears without `bias_ready`.
- An undervoltage sample in an armed state always lands in FAULT.
- Precharge pulses appear only in PRECHARGE.
- FAULT is held without a clear.
- READY is entered from PRECHARGE only on a qualifying sample.
- Each fault entry bumps the counter.

Other behaviour depends on history across many cycles, so only the bench scenarios, followed by a reference model, can show it. This covers the restart of the settle count after a dip, the exact pulse pattern, the timeout length, exact-threshold boundary samples and counter saturation.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

    typedef enum logic [1:0] {
        ST_PRECHARGE = 2'd0,
        ST_READY     = 2'd1,
        ST_SWITCHING = 2'd2,
        ST_FAULT     = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic above_on;
        logic below_off;
    } bias_flags_t;

    function automatic logic [15:0] zero_as_one16(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

endpackage

// File: rtl/bias_window_cmp.sv
module bias_window_cmp
    import bias_seq_pkg::*;
#(
    parameter int BIAS_W = 10
) (
    input  logic              valid,
    input  logic [BIAS_W-1:0] sample,
    input  logic [BIAS_W-1:0] th_on,
    input  logic [BIAS_W-1:0] th_off,
    output bias_flags_t       flags
);
    always_comb begin
        flags.valid     = valid;
        flags.above_on  = valid && (sample > th_on);
        flags.below_off = valid && (sample < th_off);
    end
endmodule

// File: rtl/pc_pulse_gen.sv
module pc_pulse_gen #(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [PC_W-1:0] period,
    input  logic [PC_W-1:0] width,
    output logic            pulse
);
    localparam int EXT_W = PC_W + 1;

    logic [PC_W-1:0]  phase_q;
    logic [EXT_W-1:0] eff_period;
    logic [EXT_W-1:0] phase_inc;

    always_comb begin
        eff_period = (period == '0) ? EXT_W'(1) : {1'b0, period};
        phase_inc  = {1'b0, phase_q} + EXT_W'(1);
        pulse      = active && (phase_q < width);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase_q <= '0;
        end else if (phase_inc >= eff_period) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_inc[PC_W-1:0];
        end
    end
endmodule

// File: rtl/startup_timers.sv
module startup_timers
    import bias_seq_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int TMO_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  bias_flags_t         flags,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [TMO_W-1:0]    timeout_len,
    output logic                qualify,
    output logic                expire
);
    localparam int SX_W = SETTLE_W + 1;
    localparam int TX_W = TMO_W + 1;

    logic [SETTLE_W-1:0] settle_q;
    logic [TMO_W-1:0]    tmo_q;
    logic [SX_W-1:0]     settle_need;
    logic [SX_W-1:0]     settle_inc;
    logic [TX_W-1:0]     tmo_inc;

    always_comb begin
        settle_need = (settle_len == '0) ? SX_W'(1) : {1'b0, settle_len};
        settle_inc  = {1'b0, settle_q} + SX_W'(1);
        tmo_inc     = {1'b0, tmo_q} + TX_W'(1);
        qualify     = active && flags.above_on && (settle_inc >= settle_need);
        expire      = active && (timeout_len != '0) && (tmo_inc >= {1'b0, timeout_len});
    end

    always_ff @(posedge clk) begin
        if (rst || !active || qualify) begin
            settle_q <= '0;
        end else if (flags.valid) begin
            if (flags.above_on) begin
                settle_q <= settle_inc[SETTLE_W-1:0];
            end else begin
                settle_q <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tmo_q <= '0;
        end else if (tmo_q != '1) begin
            tmo_q <= tmo_inc[TMO_W-1:0];
        end
    end
endmodule

// File: rtl/hs_bias_sequencer.sv
module hs_bias_sequencer
    import bias_seq_pkg::*;
#(
    parameter int BIAS_W   = 10,
    parameter int SETTLE_W = 8,
    parameter int PC_W     = 8,
    parameter int TMO_W    = 16,
    parameter int CHAT_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bias_valid,
    input  logic [BIAS_W-1:0]   bias_sample,
    input  logic [BIAS_W-1:0]   th_on,
    input  logic [BIAS_W-1:0]   th_off,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [PC_W-1:0]     pc_period,
    input  logic [PC_W-1:0]     pc_width,
    input  logic [TMO_W-1:0]    timeout_len,
    input  logic                start_req,
    input  logic                fault_clr,
    output logic [1:0]          state_o,
    output logic                pc_ls_req,
    output logic                bias_ready,
    output logic                pwm_en,
    output logic [CHAT_W-1:0]   chatter_cnt
);
    seq_state_e          state_q, state_d;
    bias_flags_t         flags;
    logic                pc_active;
    logic                qualify, expire;
    logic [CHAT_W-1:0]   chat_q;

    bias_window_cmp #(.BIAS_W(BIAS_W)) u_cmp (
        .valid  (bias_valid),
        .sample (bias_sample),
        .th_on  (th_on),
        .th_off (th_off),
        .flags  (flags)
    );

    assign pc_active = (state_q == ST_PRECHARGE) && start_req;

    startup_timers #(.SETTLE_W(SETTLE_W), .TMO_W(TMO_W)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .active      (pc_active),
        .flags       (flags),
        .settle_len  (settle_len),
        .timeout_len (timeout_len),
        .qualify     (qualify),
        .expire      (expire)
    );

    pc_pulse_gen #(.PC_W(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .active (pc_active),
        .period (pc_period),
        .width  (pc_width),
        .pulse  (pc_ls_req)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRECHARGE: begin
                if (qualify)     state_d = ST_READY;
                else if (expire) state_d = ST_FAULT;
            end
            ST_READY: begin
                if (flags.below_off) state_d = ST_FAULT;
                else if (start_req)  state_d = ST_SWITCHING;
            end
            ST_SWITCHING: begin
                if (flags.below_off) state_d = ST_FAULT;
                else if (!start_req) state_d = ST_READY;
            end
            ST_FAULT: begin
                if (fault_clr && flags.above_on) state_d = ST_PRECHARGE;
            end
            default: state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRECHARGE;
            chat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_FAULT && state_q != ST_FAULT && chat_q != '1) begin
                chat_q <= chat_q + CHAT_W'(1);
            end
        end
    end

    assign state_o     = state_q;
    assign bias_ready  = (state_q == ST_READY) || (state_q == ST_SWITCHING);
    assign pwm_en      = (state_q == ST_SWITCHING);
    assign chatter_cnt = chat_q;
endmodule

// File: rtl/bias_seq_checker.sv
module bias_seq_checker
    import bias_seq_pkg::*;
#(
    parameter int BIAS_W = 10,
    parameter int CHAT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bias_valid,
    input logic [BIAS_W-1:0] bias_sample,
    input logic [BIAS_W-1:0] th_on,
    input logic [BIAS_W-1:0] th_off,
    input logic              fault_clr,
    input logic [1:0]        state_o,
    input logic              pc_ls_req,
    input logic              bias_ready,
    input logic              pwm_en,
    input logic [CHAT_W-1:0] chatter_cnt
);
    localparam logic [1:0] S_PRE = 2'd0;
    localparam logic [1:0] S_RDY = 2'd1;
    localparam logic [1:0] S_SW  = 2'd2;
    localparam logic [1:0] S_FLT = 2'd3;

    p_fault_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        state_o == S_FLT |-> (!pwm_en && !bias_ready));

    p_pwm_needs_ready_r6: assert property (@(posedge clk) disable iff (rst)
        pwm_en |-> bias_ready);

    p_undervolt_trip_r4: assert property (@(posedge clk) disable iff (rst)
        ((state_o == S_RDY || state_o == S_SW) && bias_valid && bias_sample < th_off)
        |=> state_o == S_FLT);

    p_pulse_in_precharge_r5: assert property (@(posedge clk) disable iff (rst)
        pc_ls_req |-> state_o == S_PRE);

    p_fault_held_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_FLT && !fault_clr) |=> state_o == S_FLT);

    p_ready_qualified_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_PRE && !(bias_valid && bias_sample > th_on)) |=> state_o != S_RDY);

    p_chatter_step_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o != S_FLT && chatter_cnt != '1) |=>
        (state_o != S_FLT || chatter_cnt == $past(chatter_cnt) + CHAT_W'(1)));
endmodule

bind hs_bias_sequencer bias_seq_checker #(.BIAS_W(BIAS_W), .CHAT_W(CHAT_W)) u_chk (.*);

// File: tb/tb_hs_bias_sequencer.sv
module tb_hs_bias_sequencer;
    localparam int BW = 10;
    localparam int SW = 8;
    localparam int PW = 8;
    localparam int TW = 16;
    localparam int KW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bias_valid = 1'b0;
    logic [BW-1:0] bias_sample = '0;
    logic [BW-1:0] th_on = 10'd600;
    logic [BW-1:0] th_off = 10'd400;
    logic [SW-1:0] settle_len = 8'd4;
    logic [PW-1:0] pc_period = 8'd5;
    logic [PW-1:0] pc_width = 8'd2;
    logic [TW-1:0] timeout_len = '0;
    logic          start_req = 1'b0;
    logic          fault_clr = 1'b0;
    logic [1:0]    state_o;
    logic          pc_ls_req, bias_ready, pwm_en;
    logic [KW-1:0] chatter_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference model
    int m_state = 0, m_settle = 0, m_tmo = 0, m_phase = 0, m_chat = 0;

    always #4 clk = ~clk;

    hs_bias_sequencer dut (.*);

    always @(posedge clk) begin
        int nstate, need, per;
        bit act, above, below, qual, exp_t;
        if (rst) begin
            m_state = 0; m_settle = 0; m_tmo = 0; m_phase = 0; m_chat = 0;
        end else begin
            act   = (m_state == 0) && start_req;
            above = bias_valid && (int'(bias_sample) > int'(th_on));
            below = bias_valid && (int'(bias_sample) < int'(th_off));
            need  = (settle_len == 0) ? 1 : int'(settle_len);
            per   = (pc_period == 0) ? 1 : int'(pc_period);
            qual  = act && above && (m_settle + 1 >= need);
            exp_t = act && (timeout_len != 0) && (m_tmo + 1 >= int'(timeout_len));
            nstate = m_state;
            case (m_state)
                0: if (qual) nstate = 1; else if (exp_t) nstate = 3;
                1: if (below) nstate = 3; else if (start_req) nstate = 2;
                2: if (below) nstate = 3; else if (!start_req) nstate = 1;
                default: if (fault_clr && above) nstate = 0;
            endcase
            if (!act || qual) m_settle = 0;
            else if (bias_valid) m_settle = above ? m_settle + 1 : 0;
            if (!act) m_tmo = 0; else m_tmo = m_tmo + 1;
            if (!act) m_phase = 0; else m_phase = (m_phase + 1 >= per) ? 0 : m_phase + 1;
            if (nstate == 3 && m_state != 3 && m_chat < 15) m_chat = m_chat + 1;
            m_state = nstate;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        int exp_pc;
        exp_pc = (m_state == 0 && start_req && m_phase < int'(pc_width)) ? 1 : 0;
        chk("R1 state", int'(state_o), m_state);
        chk("R5 pc_ls_req", int'(pc_ls_req), exp_pc);
        chk("R6 bias_ready", int'(bias_ready), (m_state == 1 || m_state == 2) ? 1 : 0);
        chk("R6 pwm_en", int'(pwm_en), (m_state == 2) ? 1 : 0);
        chk("R8 chatter", int'(chatter_cnt), m_chat);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic samp(input int v, input int n);
        for (int i = 0; i < n; i++) begin
            bias_valid = 1'b1; bias_sample = BW'(v);
            tick();
        end
        bias_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bias_valid = 1'b0;
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset state", int'(state_o), 0);
        chk("R1 reset pwm", int'(pwm_en), 0);
        chk("R1 reset chatter", int'(chatter_cnt), 0);
        idle(6);                              // R5: no pulses without start_req
        start_req = 1'b1;
        idle(12);                             // R5: pulse pattern 2 of 5
        samp(300, 3); idle(2);
        samp(650, 3);
        samp(600, 1);                         // R3: equal th_on restarts
        samp(650, 3); idle(3);
        chk("R3 still precharge", int'(state_o), 0);
        samp(650, 1);
        chk("R2 ready after settle", int'(state_o), 1);
        idle(1);
        chk("R6 switching", int'(pwm_en), 1);
        start_req = 1'b0; idle(1);
        chk("R6 back to ready", int'(state_o), 1);
        start_req = 1'b1; idle(1);
        samp(400, 2);
        chk("R4 equal th_off holds", int'(state_o), 2);
        samp(399, 1);
        chk("R4 undervoltage fault", int'(state_o), 3);
        chk("R4 pwm removed", int'(pwm_en), 0);
        fault_clr = 1'b1; idle(2);
        chk("R7 clear alone", int'(state_o), 3);
        fault_clr = 1'b0; samp(700, 2);
        chk("R7 bias alone", int'(state_o), 3);
        fault_clr = 1'b1; samp(700, 1); fault_clr = 1'b0;
        chk("R7 exit to precharge", int'(state_o), 0);
        timeout_len = 16'd10;
        samp(200, 9);
        chk("R9 before timeout", int'(state_o), 0);
        samp(200, 1);
        chk("R9 timeout fault", int'(state_o), 3);
        // R9: qualification beats timeout on the same edge
        settle_len = 8'd1; timeout_len = 16'd1;
        fault_clr = 1'b1; samp(700, 1); fault_clr = 1'b0;
        samp(700, 1);
        chk("R9 ready wins tie", int'(state_o), 1);
        samp(100, 1);
        settle_len = 8'd0; pc_period = 8'd0; pc_width = 8'd1;
        timeout_len = 16'd2;
        for (int k = 0; k < 20; k++) begin
            fault_clr = 1'b1; samp(700, 1); fault_clr = 1'b0;
            samp(500, 1); idle(1);
        end
        chk("R8 saturated", int'(chatter_cnt), 15);
        // R2: settle_len 0 acts as 1
        timeout_len = '0;
        fault_clr = 1'b1; samp(700, 1); fault_clr = 1'b0;
        samp(650, 1);
        chk("R2 zero settle acts as one", int'(state_o), 1);
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule